// File: doc/BRIEF.md
# DMA Controller Command, Mask and Status Unit

This unit keeps the controller-wide control state of a four-channel DMA controller. It decodes the upper half of the controller's sixteen-byte port window (offsets 8 to 15) and holds the command byte, the per-channel mode bytes, the channel mask bits and the status byte. The status byte has a request bit per channel in its upper nibble and a terminal-count bit per channel in its lower nibble. Some offsets act only as strobes. One rewinds the byte-pointer flip-flop that the address/count logic uses. One performs a master reset. One unmasks every channel at once.

The channel service logic uses what the unit exports: the mode bytes, the mask vector, the request vector and a vector of channels that may be serviced. That last vector marks every channel that has a pending request and is not masked. In the other direction, per-channel hardware request level events and terminal-count pulses update the status byte. Per-channel address and count registers and all data movement belong elsewhere. Writes and reads at offsets 0 to 7 have no effect here and read as zero.

Top module: `dma_ctl_regs`

## Requirements
- R1: A write to offset 8 loads the command byte only when the value is zero or has no bit set except bit 2 (controller disable, exported as `ctrlDisable`). Any other value is dropped and the previous command byte stays.
- R2: A write to offset 9 selects a channel with data bits [1:0]. Data bit 2 sets (1) or clears (0) that channel's request bit (status bit 4+channel). The write always clears that channel's terminal-count bit (status bit channel).
- R3: A write to offset 10 selects a channel with data bits [1:0] and sets (data bit 2 = 1) or clears (0) that channel's mask bit. The other mask bits are unchanged.
- R4: A write to offset 11 stores the whole data byte as the mode of the channel in data bits [1:0]. Channel n's mode appears on `modeVec[8n+7:8n]`, and the other channels' modes are unchanged.
- R5: A write to offset 12 or 13 raises `ptrClear` for exactly one cycle, in the cycle after the write.
- R6: A write to offset 13 clears the command byte and the status byte and sets all four mask bits. Mode bytes are kept.
- R7: A write to offset 14 clears all mask bits. A write to offset 15 loads mask bits [3:0] from data bits [3:0].
- R8: While `rdEn` is high, `rdData` shows the status byte {request[3:0], terminal-count[3:0]} for offset 8, the mask bits in [3:0] for offset 15, and 0 for every other offset. A status read clears the terminal-count nibble at the next clock edge and keeps the request nibble.
- R9: A `tcPulse[n]` of 1 sets terminal-count bit n. This set takes priority over the clear from a status read or a request write in the same cycle.
- R10: When `reqEvt[n]` is 1, request bit n takes `reqLevel[n]`. This overrides a software request write to the same channel in the same cycle.
- R11: `eligible[n]` is 1 exactly when request bit n is set and mask bit n is clear.
- R12: After reset the command byte, status byte and mode bytes are zero, all mask bits are set and `ptrClear` is low.
- R13: Writes to offsets 0 to 7 change no state of this unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Port write strobe |
| rdEn | input | 1 | Port read strobe |
| addr | input | 4 | Port offset within the controller window |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from addr while rdEn |
| reqEvt | input | 4 | Per-channel hardware request update enable |
| reqLevel | input | 4 | Per-channel hardware request level |
| tcPulse | input | 4 | Per-channel terminal-count pulse |
| modeVec | output | 32 | Mode bytes, channel n in bits [8n+7:8n] |
| maskVec | output | 4 | Channel mask bits |
| reqVec | output | 4 | Channel request bits (status upper nibble) |
| eligible | output | 4 | Unmasked channels with a pending request |
| cmdReg | output | 8 | Current command byte |
| ctrlDisable | output | 1 | Command bit 2 |
| ptrClear | output | 1 | One-cycle byte-pointer flip-flop clear |

## Verification
The assertions take for granted that a port write and a port read never fall in the same cycle. The properties about read-clear and request-write clearing of terminal-count bits also apply only in cycles where no terminal-count pulse hits the same bits. The stimulus issues one port access per task step, and it raises the hardware inputs together with a port access only in the scenarios written to test priority. The assertions on those properties carry the no-pulse condition in their antecedents, so the priority scenarios stay legal for them.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int CH_NUM  = 4;
  localparam int CH_W    = $clog2(CH_NUM);
  localparam int BYTE_W  = 8;
  localparam int OFS_W   = 4;
  localparam int MODE_W  = CH_NUM * BYTE_W;
  localparam int SEL_BIT = 2;

  localparam logic [BYTE_W-1:0] CMD_OK_BITS = 8'h04;

  localparam logic [2:0] SUB_CMD    = 3'd0;
  localparam logic [2:0] SUB_REQ    = 3'd1;
  localparam logic [2:0] SUB_MASK1  = 3'd2;
  localparam logic [2:0] SUB_MODE   = 3'd3;
  localparam logic [2:0] SUB_PTRCLR = 3'd4;
  localparam logic [2:0] SUB_MRST   = 3'd5;
  localparam logic [2:0] SUB_UNMASK = 3'd6;
  localparam logic [2:0] SUB_MASKALL = 3'd7;

  typedef struct packed {
    logic              cmdWr;
    logic              reqWr;
    logic              maskOneWr;
    logic              modeWr;
    logic              ptrClr;
    logic              masterRst;
    logic              unmaskAll;
    logic              maskAllWr;
    logic              statRd;
    logic              maskRd;
    logic [CH_W-1:0]   chan;
    logic              selVal;
    logic [BYTE_W-1:0] data;
  } ctlStrobe_t;
endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
  import dma_ctl_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [OFS_W-1:0]  addr,
  input  logic [BYTE_W-1:0] wrData,
  output ctlStrobe_t        stb
);
  logic inWindow;
  logic [2:0] sub;

  assign inWindow = addr[OFS_W-1];
  assign sub      = addr[2:0];

  always_comb begin
    stb        = '0;
    stb.chan   = wrData[CH_W-1:0];
    stb.selVal = wrData[SEL_BIT];
    stb.data   = wrData;
    if (wrEn && inWindow) begin
      case (sub)
        SUB_CMD:     stb.cmdWr     = 1'b1;
        SUB_REQ:     stb.reqWr     = 1'b1;
        SUB_MASK1:   stb.maskOneWr = 1'b1;
        SUB_MODE:    stb.modeWr    = 1'b1;
        SUB_PTRCLR:  stb.ptrClr    = 1'b1;
        SUB_MRST:    stb.masterRst = 1'b1;
        SUB_UNMASK:  stb.unmaskAll = 1'b1;
        SUB_MASKALL: stb.maskAllWr = 1'b1;
        default:     ;
      endcase
    end
    if (rdEn && inWindow) begin
      stb.statRd = (sub == SUB_CMD);
      stb.maskRd = (sub == SUB_MASKALL);
    end
  end
endmodule

// File: rtl/dma_ctl_datapath.sv
module dma_ctl_datapath
  import dma_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [CH_NUM-1:0] reqEvt,
  input  logic [CH_NUM-1:0] reqLevel,
  input  logic [CH_NUM-1:0] tcPulse,
  output logic [BYTE_W-1:0] rdData,
  output logic [MODE_W-1:0] modeVec,
  output logic [CH_NUM-1:0] maskVec,
  output logic [CH_NUM-1:0] reqVec,
  output logic [CH_NUM-1:0] tcVec,
  output logic [CH_NUM-1:0] eligible,
  output logic [BYTE_W-1:0] cmdReg,
  output logic              ptrClear
);
  logic [BYTE_W-1:0] cmdQ;
  logic [CH_NUM-1:0] maskQ, reqQ, tcQ;
  logic              ptrQ;
  logic              cmdLegal;

  assign cmdLegal = ((stb.data & ~CMD_OK_BITS) == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ <= '0;
      ptrQ <= 1'b0;
    end else begin
      ptrQ <= stb.ptrClr | stb.masterRst;
      if (stb.masterRst)
        cmdQ <= '0;
      else if (stb.cmdWr && cmdLegal)
        cmdQ <= stb.data;
    end
  end

  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_chan
    logic              hitCh;
    logic              maskN, reqN, tcN;
    logic [BYTE_W-1:0] modeQ;

    assign hitCh = (stb.chan == CH_W'(ch));

    always_comb begin
      maskN = maskQ[ch];
      if (stb.masterRst)                maskN = 1'b1;
      else if (stb.unmaskAll)           maskN = 1'b0;
      else if (stb.maskAllWr)           maskN = stb.data[ch];
      else if (stb.maskOneWr && hitCh)  maskN = stb.selVal;

      reqN = reqQ[ch];
      if (stb.masterRst)                reqN = 1'b0;
      else if (stb.reqWr && hitCh)      reqN = stb.selVal;
      if (reqEvt[ch])                   reqN = reqLevel[ch];

      tcN = tcQ[ch];
      if (stb.masterRst || stb.statRd)  tcN = 1'b0;
      else if (stb.reqWr && hitCh)      tcN = 1'b0;
      if (tcPulse[ch])                  tcN = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskQ[ch] <= 1'b1;
        reqQ[ch]  <= 1'b0;
        tcQ[ch]   <= 1'b0;
        modeQ     <= '0;
      end else begin
        maskQ[ch] <= maskN;
        reqQ[ch]  <= reqN;
        tcQ[ch]   <= tcN;
        if (stb.modeWr && hitCh)
          modeQ <= stb.data;
      end
    end

    assign modeVec[ch*BYTE_W +: BYTE_W] = modeQ;
    assign eligible[ch] = reqQ[ch] & ~maskQ[ch];
  end

  always_comb begin
    if (stb.statRd)      rdData = BYTE_W'({reqQ, tcQ});
    else if (stb.maskRd) rdData = BYTE_W'(maskQ);
    else                 rdData = '0;
  end

  assign cmdReg   = cmdQ;
  assign maskVec  = maskQ;
  assign reqVec   = reqQ;
  assign tcVec    = tcQ;
  assign ptrClear = ptrQ;
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [3:0]        addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [3:0]        reqEvt,
  input  logic [3:0]        reqLevel,
  input  logic [3:0]        tcPulse,
  output logic [31:0]       modeVec,
  output logic [3:0]        maskVec,
  output logic [3:0]        reqVec,
  output logic [3:0]        eligible,
  output logic [7:0]        cmdReg,
  output logic              ctrlDisable,
  output logic              ptrClear
);
  ctlStrobe_t        stb;
  logic [CH_NUM-1:0] tcVec;

  dma_ctl_decode u_decode (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrData (wrData),
    .stb    (stb)
  );

  dma_ctl_datapath u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqEvt   (reqEvt),
    .reqLevel (reqLevel),
    .tcPulse  (tcPulse),
    .rdData   (rdData),
    .modeVec  (modeVec),
    .maskVec  (maskVec),
    .reqVec   (reqVec),
    .tcVec    (tcVec),
    .eligible (eligible),
    .cmdReg   (cmdReg),
    .ptrClear (ptrClear)
  );

  assign ctrlDisable = cmdReg[SEL_BIT];
endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic [3:0] addr,
  input logic [7:0] wrData,
  input logic [3:0] reqEvt,
  input logic [3:0] reqLevel,
  input logic [3:0] tcPulse,
  input logic [3:0] maskVec,
  input logic [3:0] reqVec,
  input logic [3:0] tcVec,
  input logic [3:0] eligible,
  input logic [7:0] cmdReg,
  input logic       ptrClear
);
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReg & 8'hFB) == 8'h00); // R1

  AST_CMD_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 4'd8 && (wrData & 8'hFB) != 8'h00) |=> $stable(cmdReg)); // R1

  AST_REQWR_TC: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 4'd9 && tcPulse == 4'h0) |=> tcVec[$past(wrData[1:0])] == 1'b0); // R2

  AST_PTR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ptrClear |-> $past(wrEn && (addr == 4'd12 || addr == 4'd13))); // R5

  AST_MRESET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 4'd13) |=> (maskVec == 4'hF && cmdReg == 8'h00)); // R6

  AST_RD_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr == 4'd8 && tcPulse == 4'h0) |=> tcVec == 4'h0); // R8

  AST_TC_SET: assert property (@(posedge clk) disable iff (!rstN)
    (tcPulse != 4'h0) |=> (tcVec & $past(tcPulse)) == $past(tcPulse)); // R9

  AST_HWREQ: assert property (@(posedge clk) disable iff (!rstN)
    (reqEvt != 4'h0) |=> (reqVec & $past(reqEvt)) == $past(reqLevel & reqEvt)); // R10

  AST_ELIG_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (eligible & maskVec) == 4'h0); // R11
endmodule

bind dma_ctl_regs dma_ctl_regs_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .addr     (addr),
  .wrData   (wrData),
  .reqEvt   (reqEvt),
  .reqLevel (reqLevel),
  .tcPulse  (tcPulse),
  .maskVec  (maskVec),
  .reqVec   (reqVec),
  .tcVec    (tcVec),
  .eligible (eligible),
  .cmdReg   (cmdReg),
  .ptrClear (ptrClear)
);

// File: tb/tb_dma_ctl_regs.sv
module tb_dma_ctl_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [3:0]  reqEvt = '0, reqLevel = '0, tcPulse = '0;
  logic [31:0] modeVec;
  logic [3:0]  maskVec, reqVec, eligible;
  logic [7:0]  cmdReg;
  logic        ctrlDisable, ptrClear;

  int errCnt = 0;
  int chkCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_ctl_regs dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .reqEvt(reqEvt), .reqLevel(reqLevel),
    .tcPulse(tcPulse), .modeVec(modeVec), .maskVec(maskVec), .reqVec(reqVec),
    .eligible(eligible), .cmdReg(cmdReg), .ctrlDisable(ctrlDisable),
    .ptrClear(ptrClear)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] ofs, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = ofs; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = '0; wrData = '0;
  endtask

  task automatic rdReg(input logic [3:0] ofs, output logic [7:0] v);
    @(negedge clk);
    rdEn = 1'b1; addr = ofs;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0; addr = '0;
  endtask

  task automatic hwPulse(input logic [3:0] evt, input logic [3:0] lvl, input logic [3:0] tc);
    @(negedge clk);
    reqEvt = evt; reqLevel = lvl; tcPulse = tc;
    @(negedge clk);
    reqEvt = '0; reqLevel = '0; tcPulse = '0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R12 mask", maskVec, 4'hF);
    check("R12 cmd", cmdReg, 8'h00);
    check("R12 modes", modeVec, 32'h0);
    check("R12 ptrClear", ptrClear, 1'b0);
    rdReg(4'd8, v);
    check("R12 status", v, 8'h00);
    rdReg(4'd15, v);
    check("R8 mask read", v, 8'h0F);
  endtask

  task automatic t_command();
    wrReg(4'd8, 8'h04);
    check("R1 accept 04", cmdReg, 8'h04);
    check("R1 ctrlDisable", ctrlDisable, 1'b1);
    wrReg(4'd8, 8'h10);
    check("R1 reject 10", cmdReg, 8'h04);
    wrReg(4'd8, 8'h00);
    check("R1 accept zero", cmdReg, 8'h00);
    wrReg(4'd8, 8'h84);
    check("R1 reject 84", cmdReg, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    wrReg(4'd14, 8'h00);
    check("R7 unmask all", maskVec, 4'h0);
    wrReg(4'd10, 8'h06);
    check("R3 set ch2", maskVec, 4'h4);
    wrReg(4'd10, 8'h03);
    check("R3 clear ch3 keeps ch2", maskVec, 4'h4);
    wrReg(4'd10, 8'h02);
    check("R3 clear ch2", maskVec, 4'h0);
    wrReg(4'd15, 8'hA5);
    check("R7 mask all write", maskVec, 4'h5);
    rdReg(4'd15, v);
    check("R8 mask read", v, 8'h05);
    rdReg(4'd10, v);
    check("R8 other read zero", v, 8'h00);
  endtask

  task automatic t_mode();
    wrReg(4'd11, 8'h59);
    check("R4 mode ch1", modeVec, 32'h0000_5900);
    wrReg(4'd11, 8'hA6);
    check("R4 mode ch2", modeVec, 32'h00A6_5900);
  endtask

  task automatic t_request();
    logic [7:0] v;
    wrReg(4'd14, 8'h00);
    hwPulse(4'h0, 4'h0, 4'h3);
    wrReg(4'd9, 8'h05);
    check("R2 req set ch1", reqVec, 4'h2);
    check("R11 eligible", eligible, 4'h2);
    rdReg(4'd8, v);
    check("R2 req write clears tc ch1", v, 8'h21);
    rdReg(4'd8, v);
    check("R8 read clears tc only", v, 8'h20);
    wrReg(4'd10, 8'h05);
    check("R11 masked not eligible", eligible, 4'h0);
    wrReg(4'd9, 8'h01);
    check("R2 req clear ch1", reqVec, 4'h0);
  endtask

  task automatic t_hwreq();
    wrReg(4'd14, 8'h00);
    hwPulse(4'h4, 4'h4, 4'h0);
    check("R10 hw set ch2", reqVec, 4'h4);
    check("R11 eligible ch2", eligible, 4'h4);
    @(negedge clk);
    wrEn = 1'b1; addr = 4'd9; wrData = 8'h02;
    reqEvt = 4'h4; reqLevel = 4'h4;
    @(negedge clk);
    wrEn = 1'b0; addr = '0; wrData = '0; reqEvt = '0; reqLevel = '0;
    check("R10 hw wins over sw clear", reqVec, 4'h4);
    hwPulse(4'h4, 4'h0, 4'h0);
    check("R10 hw clear ch2", reqVec, 4'h0);
  endtask

  task automatic t_tc_vs_read();
    logic [7:0] v;
    hwPulse(4'h0, 4'h0, 4'h8);
    @(negedge clk);
    rdEn = 1'b1; addr = 4'd8; tcPulse = 4'h1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0; addr = '0; tcPulse = '0;
    check("R9 read shows tc3", v, 8'h08);
    rdReg(4'd8, v);
    check("R9 tc set wins over read clear", v, 8'h01);
  endtask

  task automatic t_ptr();
    wrReg(4'd12, 8'h00);
    check("R5 ptrClear pulse", ptrClear, 1'b1);
    @(negedge clk);
    check("R5 ptrClear one cycle", ptrClear, 1'b0);
  endtask

  task automatic t_mreset();
    logic [7:0] v;
    wrReg(4'd8, 8'h04);
    wrReg(4'd14, 8'h00);
    wrReg(4'd9, 8'h07);
    hwPulse(4'h0, 4'h0, 4'h2);
    wrReg(4'd13, 8'h00);
    check("R5 ptrClear on master reset", ptrClear, 1'b1);
    check("R6 cmd cleared", cmdReg, 8'h00);
    check("R6 mask set", maskVec, 4'hF);
    check("R6 modes kept", modeVec, 32'h00A6_5900);
    rdReg(4'd8, v);
    check("R6 status cleared", v, 8'h00);
  endtask

  task automatic t_low_offsets();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) wrReg(4'(i), 8'hFF);
    check("R13 mask untouched", maskVec, 4'hF);
    check("R13 cmd untouched", cmdReg, 8'h00);
    check("R13 modes untouched", modeVec, 32'h00A6_5900);
    check("R13 req untouched", reqVec, 4'h0);
    rdReg(4'd3, v);
    check("R8 low offset reads zero", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_command();
    t_mask();
    t_mode();
    t_request();
    t_hwreq();
    t_tc_vs_read();
    t_ptr();
    t_mreset();
    t_low_offsets();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errCnt++;
        chkCnt++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule